// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Datapath

This block is the product path of a fixed-point signal-processing core. Two 16-bit signed operand registers feed a multiplier. The registered 32-bit product passes through a programmable alignment shifter, and the shifted value goes into one of two 36-bit accumulators. Each accumulator has four guard bits above its 32-bit working range. A single arithmetic-control register sets every option of the path: the product alignment, overflow saturation for each accumulator, clear-on-load of each low half, and a mirror mode in which loading the multiplier's high operand also loads the other operand. The mirror mode makes squaring a one-cycle operation.

On each cycle the surrounding core issues one operation code, an accumulator select and a 16-bit data word. The operand and accumulator registers are visible at the ports, so the sequencer and the bench can see every register that the operations touch. A registered overflow flag reports whether the most recent arithmetic result left the 32-bit range.

Top module: `mac_datapath`

## Requirements
- R1: Control word: bits 8..0 are stored when `ctl_wr` is high and read back unchanged on `ctl_rdata`. Bits 15..9 always read as zero. The register resets to zero.
- R2: While reset is held, and after it is released, the accumulators, the overflow flag and the operand registers are zero.
- R3: Operation codes on `op`: 0 idle, 1 load x, 2 load y-high, 3 load y-low, 4 load the selected accumulator's high half, 5 add, 6 subtract, 7 load the aligned product. `acc_sel` = 0 selects a0 and 1 selects a1. Operations 4 to 7 change only the selected accumulator.
- R4: The product register takes x·y-high (signed) on the clock edge after the operands are registered. An accumulate operation uses the product register as it stands at its own edge, so it needs one idle cycle after the last operand load.
- R5: Alignment field (control bits 1..0): 00 passes p unchanged, and 01 passes p arithmetically shifted right by 2. The product is sign-extended to 36 bits before it is shifted.
- R6: Alignment 10 passes p·4 and alignment 11 passes p·2. Zeros fill the vacated low bits, and the bits shifted out of the 32-bit range land in the guard bits.
- R7: When saturation is enabled (control bit 2 for a0, bit 3 for a1, value 0), an add, subtract or product-load result outside the signed 32-bit range is stored as 0x0_7FFF_FFFF or 0xF_8000_0000, chosen by its sign.
- R8: When an accumulator's saturation bit is 1, its result wraps modulo 2^36 and the guard bits keep the overflow. Each accumulator follows only its own bit.
- R9: `ovf` is high on the cycle after an arithmetic operation whose 36-bit result is outside the signed 32-bit range, whatever the saturation setting. It is low on the cycle after any other operation.
- R10: Loading y-high clears y-low unless control bit 6 is 1. If bit 6 is 1, y-low keeps its value. `y_out` = {y-high, y-low}.
- R11: Loading an accumulator's high half sign-extends the word into bits 35..16. It clears bits 15..0 unless the accumulator's clear-disable bit is 1 (bit 4 for a0, bit 5 for a1).
- R12: With control bit 7 set, loading y-high also loads x with the same word, so the product after the idle cycle is the square.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word to write |
| ctl_rdata | output | 16 | Control word read-back |
| op | input | 3 | Operation code |
| acc_sel | input | 1 | Accumulator select for ops 4 to 7 |
| din | input | 16 | Data word for load operations |
| x_out | output | 16 | x operand register |
| y_out | output | 32 | y register, high half then low half |
| a0 | output | 36 | Accumulator 0 |
| a1 | output | 36 | Accumulator 1 |
| ovf | output | 1 | Overflow of the last arithmetic result |

## Verification
The bench checks the arithmetic shift with a negative product that is not a multiple of four. A logical shift or a truncating divide would then give a value one away or a huge positive number. Saturation is driven with the most negative operands times four, in both directions, with a0 clamping and a1 wrapping in the same setting. A design that shares one saturation bit, or clamps on the 36-bit limits, would corrupt one of the two. An operation issued directly after the last operand load must see the previous product, which exposes a missing or extra pipeline stage. The clear-disable bits and the mirror mode are checked through the low halves and x. A swapped bit index there would clear or keep the wrong register.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_LDX  = 3'd1,
      OP_LDYH = 3'd2,
      OP_LDYL = 3'd3,
      OP_LDAH = 3'd4,
      OP_ADD  = 3'd5,
      OP_SUB  = 3'd6,
      OP_LDP  = 3'd7
   } mac_op_e;

   localparam int CTL_W       = 9;
   localparam int CB_ALIGN_LO = 0;
   localparam int CB_SATD0    = 2;
   localparam int CB_CLRD0    = 4;
   localparam int CB_CLRDY    = 6;
   localparam int CB_MIRROR   = 7;
   localparam int CB_PNG      = 8;

   typedef enum logic [1:0] {
      AL_UNITY = 2'b00,
      AL_QUART = 2'b01,
      AL_QUAD  = 2'b10,
      AL_DOUB  = 2'b11
   } align_e;

endpackage

// File: rtl/mac_align.sv
`timescale 1ns/1ps
module mac_align #(
   parameter int PW = 32,
   parameter int AW = 36
) (
   input  logic [PW-1:0] prod_i,
   input  logic [1:0]    mode_i,
   output logic [AW-1:0] algn_o
);
   import mac_pkg::*;

   localparam int GW = AW - PW;

   generate
      if (GW < 2) begin : g_bad
         $error("mac_align: accumulator needs at least two guard bits");
      end
   endgenerate

   logic signed [AW-1:0] ext;
   assign ext = $signed({{GW{prod_i[PW-1]}}, prod_i});

   always_comb begin
      case (align_e'(mode_i))
         AL_UNITY: algn_o = ext;
         AL_QUART: algn_o = ext >>> 2;
         AL_QUAD:  algn_o = ext << 2;
         default:  algn_o = ext << 1;
      endcase
   end
endmodule

// File: rtl/mac_acc_lane.sv
`timescale 1ns/1ps
module mac_acc_lane #(
   parameter int DW    = 16,
   parameter int GUARD = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  mac_pkg::mac_op_e   op_i,
   input  logic [DW-1:0]      din_i,
   input  logic [2*DW+GUARD-1:0] addend_i,
   input  logic               sat_dis_i,
   input  logic               clr_dis_i,
   output logic [2*DW+GUARD-1:0] acc_o,
   output logic               ovf_o
);
   import mac_pkg::*;

   localparam int AW  = 2*DW + GUARD;
   localparam int TOP = 2*DW - 1;
   localparam logic [AW-1:0] SAT_POS = {{(GUARD+1){1'b0}}, {TOP{1'b1}}};
   localparam logic [AW-1:0] SAT_NEG = {{(GUARD+1){1'b1}}, {TOP{1'b0}}};

   logic [AW-1:0] acc_q, raw;
   logic          ovf_q, arith, ld_hi, fits;

   assign arith = sel_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_LDP);
   assign ld_hi = sel_i && (op_i == OP_LDAH);

   always_comb begin
      case (op_i)
         OP_ADD:  raw = acc_q + addend_i;
         OP_SUB:  raw = acc_q - addend_i;
         default: raw = addend_i;
      endcase
   end

   assign fits = (&raw[AW-1:TOP]) || !(|raw[AW-1:TOP]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= arith && !fits;
         if (ld_hi)
            acc_q <= {{GUARD{din_i[DW-1]}}, din_i,
                      (clr_dis_i ? acc_q[DW-1:0] : {DW{1'b0}})};
         else if (arith) begin
            if (fits || sat_dis_i) acc_q <= raw;
            else                   acc_q <= raw[AW-1] ? SAT_NEG : SAT_POS;
         end
      end
   end

   assign acc_o = acc_q;
   assign ovf_o = ovf_q;

   // R7: a saturating result never leaves the signed 32-bit range
   p_sat_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arith && !sat_dis_i) |->
         ((&acc_q[AW-1:TOP]) || !(|acc_q[AW-1:TOP])));

   p_low_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ld_hi && !clr_dis_i) |-> (acc_q[DW-1:0] == '0));

   p_low_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && clr_dis_i) |=> (acc_q[DW-1:0] == $past(acc_q[DW-1:0])));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i) |=> $stable(acc_q));
endmodule

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath #(
   parameter int DW    = 16,
   parameter int GUARD = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_wr,
   input  logic [15:0]           ctl_wdata,
   output logic [15:0]           ctl_rdata,
   input  logic [2:0]            op,
   input  logic                  acc_sel,
   input  logic [DW-1:0]         din,
   output logic [DW-1:0]         x_out,
   output logic [2*DW-1:0]       y_out,
   output logic [2*DW+GUARD-1:0] a0,
   output logic [2*DW+GUARD-1:0] a1,
   output logic                  ovf
);
   import mac_pkg::*;

   localparam int PW   = 2*DW;
   localparam int AW   = PW + GUARD;
   localparam int NACC = 2;

   generate
      if (DW < 4)     begin : g_dw_bad  $error("mac_datapath: DW too small"); end
      if (GUARD < 2)  begin : g_gd_bad  $error("mac_datapath: GUARD too small"); end
   endgenerate

   mac_op_e         op_e;
   logic [CTL_W-1:0] ctl_q;
   logic [DW-1:0]   x_q, yh_q, yl_q;
   logic [PW-1:0]   p_q;
   logic [AW-1:0]   aligned;
   logic [AW-1:0]   acc   [NACC];
   logic [NACC-1:0] ovf_l;

   assign op_e = mac_op_e'(op);

   // control word
   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_wdata[CTL_W-1:0];
   end
   assign ctl_rdata = {{(16-CTL_W){1'b0}}, ctl_q};

   // operand registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q  <= '0;
         yh_q <= '0;
         yl_q <= '0;
      end else begin
         case (op_e)
            OP_LDX:  x_q <= din;
            OP_LDYH: begin
               yh_q <= din;
               if (ctl_q[CB_MIRROR]) x_q  <= din;
               if (!ctl_q[CB_CLRDY]) yl_q <= '0;
            end
            OP_LDYL: yl_q <= din;
            default: ;
         endcase
      end
   end

   // product register
   always_ff @(posedge clk) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= $signed(x_q) * $signed(yh_q);
   end

   mac_align #(.PW(PW), .AW(AW)) u_align (
      .prod_i (p_q),
      .mode_i (ctl_q[CB_ALIGN_LO +: 2]),
      .algn_o (aligned)
   );

   generate
      for (genvar i = 0; i < NACC; i++) begin : g_lane
         mac_acc_lane #(.DW(DW), .GUARD(GUARD)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_i     (acc_sel == 1'(i)),
            .op_i      (op_e),
            .din_i     (din),
            .addend_i  (aligned),
            .sat_dis_i (ctl_q[CB_SATD0 + i]),
            .clr_dis_i (ctl_q[CB_CLRD0 + i]),
            .acc_o     (acc[i]),
            .ovf_o     (ovf_l[i])
         );
      end
   endgenerate

   assign a0    = acc[0];
   assign a1    = acc[1];
   assign ovf   = |ovf_l;
   assign x_out = x_q;
   assign y_out = {yh_q, yl_q};

   p_mirror_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_LDYH && ctl_q[CB_MIRROR]) |=> (x_q == yh_q));

   p_ylo_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_LDYH && ctl_q[CB_CLRDY]) |=> $stable(yl_q));

   p_ovf_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(op_e == OP_ADD || op_e == OP_SUB || op_e == OP_LDP));

   p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovf_l));
endmodule

// File: tb/test_mac_datapath.sv
`timescale 1ns/1ps
module test_mac_datapath;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic [2:0]  op = '0;
   logic        acc_sel = 1'b0;
   logic [15:0] din = '0;
   logic [15:0] x_out;
   logic [31:0] y_out;
   logic [35:0] a0, a1;
   logic        ovf;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   mac_datapath i_mac_datapath (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .op(op), .acc_sel(acc_sel), .din(din),
      .x_out(x_out), .y_out(y_out), .a0(a0), .a1(a1), .ovf(ovf)
   );

   function automatic logic [35:0] w36(longint v);
      return v[35:0];
   endfunction

   task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic issue(logic [2:0] o, logic s, logic [15:0] d);
      op = o; acc_sel = s; din = d;
      @(negedge clk);
      op = 3'd0; din = '0;
   endtask

   task automatic set_ctl(logic [15:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic mac(logic [15:0] xv, logic [15:0] yv, logic [2:0] o, logic s);
      issue(3'd1, 1'b0, xv);
      issue(3'd2, 1'b0, yv);
      issue(3'd0, 1'b0, '0);
      issue(o, s, '0);
   endtask

   task automatic t_reset;
      chk("R2 a0", 64'(a0), 0);
      chk("R2 a1", 64'(a1), 0);
      chk("R2 ovf", 64'(ovf), 0);
      chk("R2 x", 64'(x_out), 0);
      chk("R1 reset ctl", 64'(ctl_rdata), 0);
   endtask

   task automatic t_ctl;
      set_ctl(16'hFFFF);
      chk("R1 readback ones", 64'(ctl_rdata), 64'h01FF);
      set_ctl(16'hA155);
      chk("R1 readback pattern", 64'(ctl_rdata), 64'h0155);
      set_ctl(16'h0000);
   endtask

   task automatic t_align;
      set_ctl(16'h0000);
      mac(-16'sd3, 16'sd5, 3'd7, 1'b0);
      chk("R5 align unity", 64'(a0), 64'(w36(-15)));
      set_ctl(16'h0001);
      mac(-16'sd7, 16'sd101, 3'd7, 1'b0);
      chk("R5 align quarter negative", 64'(a0), 64'(w36(-177)));
      set_ctl(16'h0002);
      mac(16'sd25, 16'sd40, 3'd7, 1'b0);
      chk("R6 align x4", 64'(a0), 64'd4000);
      set_ctl(16'h0003);
      mac(16'sd25, 16'sd40, 3'd7, 1'b0);
      chk("R6 align x2", 64'(a0), 64'd2000);
   endtask

   task automatic t_addsub;
      set_ctl(16'h0000);
      issue(3'd4, 1'b1, 16'h0002);
      mac(16'sd10, 16'sd10, 3'd7, 1'b0);
      chk("R3 load product a0", 64'(a0), 64'd100);
      mac(16'sd3, 16'sd4, 3'd5, 1'b0);
      chk("R3 add a0", 64'(a0), 64'd112);
      mac(16'sd5, 16'sd5, 3'd6, 1'b0);
      chk("R3 sub a0", 64'(a0), 64'd87);
      chk("R3 a1 untouched", 64'(a1), 64'h20000);
      issue(3'd6, 1'b1, '0);
      chk("R3 sub a1", 64'(a1), 64'h20000 - 25);
      chk("R3 a0 untouched", 64'(a0), 64'd87);
   endtask

   task automatic t_sat;
      set_ctl(16'h000A);
      mac(16'h8000, 16'h8000, 3'd7, 1'b0);
      chk("R7 clamp positive", 64'(a0), 64'h0_7FFF_FFFF);
      chk("R9 ovf saturating", 64'(ovf), 1);
      issue(3'd7, 1'b1, '0);
      chk("R8 wrap a1 positive", 64'(a1), 64'h1_0000_0000);
      chk("R9 ovf wrapping", 64'(ovf), 1);
      issue(3'd0, 1'b0, '0);
      chk("R9 ovf clears", 64'(ovf), 0);
      mac(16'h8000, 16'h7FFF, 3'd7, 1'b0);
      chk("R7 clamp negative", 64'(a0), 64'hF_8000_0000);
      issue(3'd7, 1'b1, '0);
      chk("R8 wrap a1 negative", 64'(a1), 64'hF_0002_0000);
      set_ctl(16'h0000);
      mac(16'sd2, 16'sd3, 3'd7, 1'b0);
      chk("R9 no ovf in range", 64'(ovf), 0);
   endtask

   task automatic t_lowclr;
      set_ctl(16'h0000);
      mac(16'sd10, 16'sd100, 3'd7, 1'b0);
      issue(3'd4, 1'b0, 16'h0005);
      chk("R11 a0 low cleared", 64'(a0), 64'h0_0005_0000);
      set_ctl(16'h0010);
      mac(16'sd10, 16'sd100, 3'd7, 1'b0);
      issue(3'd4, 1'b0, 16'hFFFF);
      chk("R11 a0 low kept, sign extend", 64'(a0), 64'hF_FFFF_03E8);
      mac(16'sd1, 16'sd9, 3'd7, 1'b1);
      issue(3'd4, 1'b1, 16'h0007);
      chk("R11 a1 own flag clears", 64'(a1), 64'h0_0007_0000);
   endtask

   task automatic t_ylo;
      set_ctl(16'h0000);
      issue(3'd3, 1'b0, 16'h1234);
      issue(3'd2, 1'b0, 16'h0002);
      chk("R10 y-low cleared", 64'(y_out), 64'h0002_0000);
      set_ctl(16'h0040);
      issue(3'd3, 1'b0, 16'h1234);
      issue(3'd2, 1'b0, 16'h0002);
      chk("R10 y-low kept", 64'(y_out), 64'h0002_1234);
   endtask

   task automatic t_mirror_timing;
      set_ctl(16'h0080);
      issue(3'd1, 1'b0, 16'h0011);
      issue(3'd2, 1'b0, 16'hFFFD);
      chk("R12 x mirrors y", 64'(x_out), 64'hFFFD);
      issue(3'd0, 1'b0, '0);
      issue(3'd7, 1'b0, '0);
      chk("R12 square", 64'(a0), 64'd9);
      set_ctl(16'h0000);
      issue(3'd1, 1'b0, 16'h0002);
      issue(3'd2, 1'b0, 16'h0002);
      issue(3'd7, 1'b0, '0);
      chk("R4 previous product", 64'(a0), 64'(w36(-6)));
      issue(3'd7, 1'b0, '0);
      chk("R4 new product", 64'(a0), 64'd4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ctl;
      t_align;
      t_addsub;
      t_sat;
      t_lowclr;
      t_ylo;
      t_mirror_timing;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule